// File: doc/BRIEF.md
# Half-Duplex Serial Peripheral Slave Byte Engine

This block is the pin-level front end of a serial-peripheral slave. It watches the chip-select, serial clock and serial input pins, brings them into a faster system clock domain, and turns their activity into whole bytes. It hands each received byte to the layer above with a one-cycle valid strobe. It also takes response bytes from that layer through a request/taken handshake and shifts them out, most-significant bit first. Command decoding, register storage and arbitration among several masters belong to the layer above and are not part of this block.

Transfers are half-duplex. The serial output is enabled only while a response byte is being shifted out. While that happens, the serial input is ignored. The engine accepts clock-polarity modes 0 and 3 with no mode setting, because it only acts on rising serial-clock edges and on falling edges inside a byte. The output enable and the data bit are separate ports, so a pad cell outside the block can build the tri-state driver.

Raising chip-select ends the transaction. Any bits of a byte that has not yet received all eight edges are discarded, and the bit position returns to the start for the next transaction. The system clock must run at least four times faster than the serial clock.

Top module: `spi_byte_slave`

## Requirements
- R1: After synchronous reset, spi_miso_oe, rx_valid, tx_taken, xfer_start and xfer_end are all 0.
- R2: In a receive byte, spi_mosi is sampled on each of eight spi_sck rising edges, most-significant bit first. After the eighth edge, rx_valid pulses for exactly one cycle and rx_data holds the assembled byte.
- R3: While spi_cs_n stays low, successive groups of eight rising edges produce successive bytes. Receive and transmit bytes can be mixed in any order within one transaction.
- R4: Mode 0 (spi_sck idles low) and mode 3 (spi_sck idles high) both give the same bytes, and no input selects between them.
- R5: If spi_cs_n rises before a byte is complete, the partial bits give no rx_valid. The next transaction starts again at the most-significant bit.
- R6: Each falling edge of spi_cs_n gives one xfer_start pulse, and each rising edge gives one xfer_end pulse.
- R7: If tx_request is high at a byte boundary while spi_cs_n is low, tx_data is loaded and tx_taken pulses once. The loaded byte then appears on spi_miso most-significant bit first. Each bit is valid before the spi_sck rising edge that samples it, and the next bit appears after the following falling edge.
- R8: spi_miso_oe is 1 only during a transmit byte. It is 0 during receive bytes, after the eighth rising edge of a transmit byte, and while spi_cs_n is high.
- R9: During a transmit byte, activity on spi_mosi produces no rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the slave |
| spi_miso | output | 1 | Serial data out of the slave |
| spi_miso_oe | output | 1 | Output enable for the spi_miso pad driver |
| rx_valid | output | 1 | One-cycle strobe for a completed received byte |
| rx_data | output | 8 | Received byte, valid with rx_valid |
| tx_request | input | 1 | The upper layer has a response byte ready |
| tx_data | input | 8 | Response byte to send |
| tx_taken | output | 1 | One-cycle strobe when tx_data has been loaded |
| xfer_start | output | 1 | One-cycle strobe at the start of a transaction |
| xfer_end | output | 1 | One-cycle strobe at the end of a transaction |

## Verification
The assertions check the following on every cycle:
- the strobes are single-cycle;
- tx_taken only follows a pending tx_request;
- the output enable never overlaps a received-byte strobe;
- the output enable is low at a transaction end and while chip-select has been idle.

Only the bench scenarios can show the rest:
- the values of the assembled bytes;
- the bit order on spi_miso, and that it is valid at each master sampling edge;
- that mode 3 behaves like mode 0;
- that a truncated byte leaves nothing behind for the next transaction.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned PIN_CNT     = 3;
  // pin slot order inside the synchronizer bank
  localparam int unsigned PIN_SI  = 0;
  localparam int unsigned PIN_SCK = 1;
  localparam int unsigned PIN_CS  = 2;
  typedef enum logic { PH_RX = 1'b0, PH_TX = 1'b1 } phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins_in,
  output logic [WIDTH-1:0] pins_sync
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_pin
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[g]}};
        else     chain <= {chain[STAGES-2:0], pins_in[g]};
      end
      assign pins_sync[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic prev;
  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= level;
  end
  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift_en,
  output logic         dout
);
  logic [W-1:0] sh;
  always_ff @(posedge clk) begin
    if (rst)           sh <= '0;
    else if (load)     sh <= load_word;
    else if (shift_en) sh <= {sh[W-2:0], 1'b0};
  end
  assign dout = sh[W-1];
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
  import spi_byte_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         spi_sck,
  input  logic         spi_cs_n,
  input  logic         spi_mosi,
  output logic         spi_miso,
  output logic         spi_miso_oe,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  input  logic         tx_request,
  input  logic [W-1:0] tx_data,
  output logic         tx_taken,
  output logic         xfer_start,
  output logic         xfer_end
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

  logic [PIN_CNT-1:0] raw_pins, sync_pins;
  logic sck_s, cs_s, si_s;
  logic sck_rise, sck_fall, cs_rise, cs_fall;

  assign raw_pins[PIN_SI]  = spi_mosi;
  assign raw_pins[PIN_SCK] = spi_sck;
  assign raw_pins[PIN_CS]  = spi_cs_n;

  spi_pin_sync #(
    .WIDTH(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst(rst), .pins_in(raw_pins), .pins_sync(sync_pins)
  );

  assign si_s  = sync_pins[PIN_SI];
  assign sck_s = sync_pins[PIN_SCK];
  assign cs_s  = sync_pins[PIN_CS];

  spi_edge_det #(.RST_VAL(1'b0)) u_sck_edge (
    .clk(clk), .rst(rst), .level(sck_s), .rise(sck_rise), .fall(sck_fall)
  );
  spi_edge_det #(.RST_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst(rst), .level(cs_s), .rise(cs_rise), .fall(cs_fall)
  );

  phase_e           phase;
  logic [CNT_W-1:0] bit_cnt;
  logic             at_boundary, do_load, rx_shift, tx_shift, last_edge;
  logic [W-1:0]     rx_word;
  logic             so_bit;

  // a byte boundary is bit position 0 with no transmit byte pending
  assign at_boundary = !cs_s && (bit_cnt == '0) && (phase == PH_RX);
  assign do_load     = at_boundary && tx_request && !sck_rise;
  assign rx_shift    = !cs_s && sck_rise && (phase == PH_RX);
  // the first falling edge of a byte (mode 3 lead-in, or mode 0 tail) never shifts
  assign tx_shift    = !cs_s && sck_fall && (phase == PH_TX) && (bit_cnt != '0);
  assign last_edge   = sck_rise && (bit_cnt == LAST_BIT);

  spi_rx_shift #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .shift_en(rx_shift), .din(si_s), .word(rx_word)
  );

  spi_tx_shift #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .load(do_load), .load_word(tx_data),
    .shift_en(tx_shift), .dout(so_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_RX;
      bit_cnt    <= '0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      tx_taken   <= 1'b0;
      xfer_start <= 1'b0;
      xfer_end   <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      tx_taken   <= 1'b0;
      xfer_start <= cs_fall;
      xfer_end   <= cs_rise;
      if (cs_s) begin
        // deselected: drop any partial byte and return to bit 0
        phase   <= PH_RX;
        bit_cnt <= '0;
      end else begin
        if (do_load) begin
          phase    <= PH_TX;
          tx_taken <= 1'b1;
        end
        if (sck_rise) begin
          bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
          if (last_edge) begin
            if (phase == PH_RX) begin
              rx_valid <= 1'b1;
              rx_data  <= {rx_word[W-2:0], si_s};
            end
            phase <= PH_RX;
          end
        end
      end
    end
  end

  assign spi_miso_oe = (phase == PH_TX);
  assign spi_miso    = so_bit & (phase == PH_TX);
endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_miso_oe,
  input logic rx_valid,
  input logic tx_request,
  input logic tx_taken,
  input logic xfer_start,
  input logic xfer_end
);
  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R2
  AST_NO_RX_WHILE_TX: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && spi_miso_oe)); // R9
  AST_TAKEN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tx_taken |=> !tx_taken); // R7
  AST_TAKEN_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    tx_taken |-> $past(tx_request)); // R7
  AST_START_END_APART: assert property (@(posedge clk) disable iff (rst)
    !(xfer_start && xfer_end)); // R6
  AST_END_NO_OE: assert property (@(posedge clk) disable iff (rst)
    xfer_end |-> !spi_miso_oe); // R8
  AST_IDLE_NO_OE: assert property (@(posedge clk) disable iff (rst)
    ($past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe); // R8
endmodule

bind spi_byte_slave spi_byte_slave_chk u_chk (.*);

// File: tb/spi_byte_slave_bench.sv
module spi_byte_slave_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe, rx_valid, tx_taken, xfer_start, xfer_end;
  logic [7:0] rx_data;
  logic tx_request = 1'b0;
  logic [7:0] tx_data = '0;

  int total = 0, bad = 0;
  int seen_start = 0, seen_end = 0, want_start = 0, want_end = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  spi_byte_slave u_spi_byte_slave (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_request(tx_request),
    .tx_data(tx_data), .tx_taken(tx_taken), .xfer_start(xfer_start),
    .xfer_end(xfer_end)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected received bytes as strobes appear
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rx_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected byte", int'(rx_data), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R2 received byte", int'(rx_data), int'(e));
        end
      end
      if (xfer_start) seen_start++;
      if (xfer_end)   seen_end++;
    end
  end

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic open_xfer(input bit m3);
    spi_sck = m3;
    half();
    spi_cs_n = 1'b0;
    want_start++;
    half();
  endtask

  task automatic close_xfer(input bit m3);
    half();
    spi_sck = m3;
    half();
    spi_cs_n = 1'b1;
    want_end++;
    half(); half();
  endtask

  task automatic byte_io(input logic [7:0] mo, input bit is_tx, input logic [7:0] exp_so,
                         input string req);
    logic [7:0] got;
    int oe_bad;
    oe_bad = 0;
    for (int i = 7; i >= 0; i--) begin
      spi_sck = 1'b0;
      spi_mosi = mo[i];
      half();
      spi_sck = 1'b1;
      got[i] = spi_miso;
      if (spi_miso_oe !== is_tx) oe_bad++;
      half();
    end
    if (is_tx) chk(got == exp_so, req, int'(got), int'(exp_so));
    chk(oe_bad == 0, "R8 enable during byte", oe_bad, 0);
  endtask

  task automatic rx_byte(input logic [7:0] b, input string req);
    exp_q.push_back(b);
    byte_io(b, 1'b0, 8'h00, req);
  endtask

  task automatic offer_tx(input logic [7:0] b);
    tx_data = b;
    tx_request = 1'b1;
    do @(negedge clk); while (!tx_taken);
    tx_request = 1'b0;
  endtask

  task automatic settle(input string req);
    half(); half();
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    chk(seen_start == want_start, "R6 start count", seen_start, want_start);
    chk(seen_end == want_end, "R6 end count", seen_end, want_end);
    chk(spi_miso_oe == 1'b0, "R8 idle enable", int'(spi_miso_oe), 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(spi_miso_oe == 1'b0, "R1 oe", int'(spi_miso_oe), 0);
    chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    chk(tx_taken == 1'b0, "R1 tx_taken", int'(tx_taken), 0);
    chk(!xfer_start && !xfer_end, "R1 xfer strobes", int'({xfer_start, xfer_end}), 0);
    half();

    // R2 single byte, mode 0
    open_xfer(1'b0); rx_byte(8'hA5, "R2 one byte"); close_xfer(1'b0);
    settle("R2 missing byte");

    // R3 three bytes under one select
    open_xfer(1'b0);
    rx_byte(8'h3C, "R3"); rx_byte(8'h81, "R3"); rx_byte(8'hFF, "R3");
    close_xfer(1'b0);
    settle("R3 missing byte");

    // R4 mode 3
    open_xfer(1'b1); rx_byte(8'h5A, "R4"); rx_byte(8'h00, "R4"); close_xfer(1'b1);
    settle("R4 missing byte");

    // R5 partial byte dropped, next transaction realigned
    open_xfer(1'b0);
    for (int i = 0; i < 5; i++) begin
      spi_sck = 1'b0; spi_mosi = i[0]; half(); spi_sck = 1'b1; half();
    end
    close_xfer(1'b0);
    settle("R5 partial");
    open_xfer(1'b0); rx_byte(8'hC3, "R5 realigned"); close_xfer(1'b0);
    settle("R5 missing byte");

    // R7 R9 command byte, two response bytes with mosi noise, then a received byte
    open_xfer(1'b0);
    rx_byte(8'h12, "R3 command");
    offer_tx(8'h9B);
    byte_io(8'hFF, 1'b1, 8'h9B, "R7 first response");
    offer_tx(8'h64);
    byte_io(8'hA7, 1'b1, 8'h64, "R7 second response");
    rx_byte(8'h7E, "R3 after response");
    close_xfer(1'b0);
    settle("R9 stray byte");

    // R4 R7 response in mode 3 right at select
    open_xfer(1'b1);
    offer_tx(8'hE1);
    byte_io(8'h5F, 1'b1, 8'hE1, "R4 mode 3 response");
    close_xfer(1'b1);
    settle("R4 mode 3");

    // R8 R5 response cut short by deselect
    open_xfer(1'b0);
    offer_tx(8'hC6);
    for (int i = 0; i < 3; i++) begin
      spi_sck = 1'b0; half(); spi_sck = 1'b1; half();
    end
    close_xfer(1'b0);
    settle("R8 cut response");
    open_xfer(1'b0); rx_byte(8'h11, "R5 after cut response"); close_xfer(1'b0);
    settle("R5 after cut");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule